// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the sequence of column addresses that a synchronous DRAM walks through during one read or write burst. A column command presents a starting column together with a burst-length code and an ordering select. In that same cycle the block emits the starting column as beat 0. On each following clock it emits the next column of the burst, until the burst runs out, a burst-stop arrives, or another column command takes over. Row and bank handling, the data array and the CAS-latency pipeline sit outside this block. It is meant for a DRAM model or a device-side column path.

Bursts of 2, 4 or 8 beats stay inside the naturally aligned block of that size that contains the starting column. The beats follow either linear wrap-around order or XOR (interleaved) order. A full-page burst walks all 256 columns of the page and keeps going until it is stopped. The length code and the order select are captured when the column command is accepted. They apply to that burst only.

Top module: `sdr_burst_colseq`

## Requirements
- R1: In a cycle with `col_go` high, `beat_valid` is 1 and `beat_col` equals `col_start` in that same cycle (beat 0). No register lies between these inputs and the outputs.
- R2: `len_code` selects the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives a full page. A burst presents exactly that many valid beats on consecutive cycles. After the last beat, `beat_valid` is 0 unless a new command arrives.
- R3: With `order_ilv` = 0 and length L in {2,4,8}, beat i has column {upper bits of start, (start mod L + i) mod L}. The bits above log2(L) never change during the burst.
- R4: With `order_ilv` = 1 and length L in {2,4,8}, beat i has column {upper bits of start, (start mod L) XOR i}.
- R5: A full-page burst emits (start + i) mod 256 without end and ignores `order_ilv`.
- R6: `beat_last` is 1 only on beat L-1 of a burst with finite length. It is never 1 during a full-page burst.
- R7: `burst_halt` without `col_go` leaves the beat of its own cycle in place. From the next cycle on, no beats are emitted.
- R8: A `col_go` during a running burst restarts the sequence at the new column and with the new settings in that cycle. `col_go` takes priority over `burst_halt` in the same cycle.
- R9: Changes on `len_code` and `order_ilv` while a burst runs (with `col_go` low) have no effect on that burst.
- R10: While `rst` is high and after its release, `beat_valid` is 0 until the first `col_go`.
- R11: The reserved codes 3'b100, 3'b101 and 3'b110 behave as a length of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| col_go | input | 1 | Column command accepted this cycle |
| col_start | input | 8 | Starting column of the new burst |
| len_code | input | 3 | Burst length code (see R2, R11) |
| order_ilv | input | 1 | 0 = sequential order, 1 = interleaved order |
| burst_halt | input | 1 | Burst-stop command |
| beat_valid | output | 1 | A column address is presented this cycle |
| beat_col | output | 8 | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final beat of the burst |

## Verification
The bench starts bursts at columns that are not aligned to the burst block, so the wrap inside the block shows up. A design that carried into the upper bits would leave the block. A design that confused the XOR order with the linear order would emit the wrong column from beat 1 on. A full-page run of more than 256 beats from column 0xFE checks the page wrap. A design that stopped the burst, raised `beat_last`, or honoured the interleaved select there would be caught by that run. Further scenarios cover a restart in the middle of a burst, a stop colliding with a new command, reserved length codes and changes to the settings in mid-burst. A design that kept the old burst running, let the stop win, or read the settings live would show the wrong beat count or wrong columns.

// File: rtl/sdr_bseq_pkg.sv
package sdr_bseq_pkg;

    // Column address width of one page.
    localparam int SDR_COL_W = 8;

    // Captured burst mode: page flag, order select and log2 of the finite length.
    typedef struct packed {
        logic       page;
        logic       ilv;
        logic [1:0] lg;
    } bmode_t;

    // Length code decode; reserved codes fall back to a single beat.
    function automatic bmode_t decode_mode(input logic [2:0] code, input logic ilv);
        bmode_t m;
        m.page = 1'b0;
        m.lg   = 2'd0;
        case (code)
            3'b001:  m.lg = 2'd1;
            3'b010:  m.lg = 2'd2;
            3'b011:  m.lg = 2'd3;
            3'b111:  m.page = 1'b1;
            default: m.lg = 2'd0;
        endcase
        m.ilv = ilv & ~m.page;
        return m;
    endfunction

    // Bits of the column that move during the burst.
    function automatic logic [SDR_COL_W-1:0] span_mask(input bmode_t m);
        if (m.page)
            return {SDR_COL_W{1'b1}};
        return SDR_COL_W'((32'd1 << m.lg) - 32'd1);
    endfunction

    // Column for beat number idx of a burst starting at base.
    function automatic logic [SDR_COL_W-1:0] beat_addr(input logic [SDR_COL_W-1:0] base,
                                                       input logic [SDR_COL_W-1:0] idx,
                                                       input bmode_t m);
        logic [SDR_COL_W-1:0] mask;
        logic [SDR_COL_W-1:0] moved;
        mask  = span_mask(m);
        moved = m.ilv ? (base ^ idx) : (base + idx);
        return (base & ~mask) | (moved & mask);
    endfunction

endpackage

// File: rtl/sdr_bseq_addr.sv
module sdr_bseq_addr
    import sdr_bseq_pkg::*;
#(
    parameter int COL_W = SDR_COL_W
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  bmode_t           mode,
    output logic [COL_W-1:0] col,
    output logic             last
);
    logic [COL_W-1:0] mask;

    always_comb begin
        mask = span_mask(mode);
        col  = beat_addr(base, idx, mode);
        // Final beat index equals length minus one, which is the span mask.
        last = ~mode.page & (idx == mask);
    end
endmodule

// File: rtl/sdr_bseq_state.sv
module sdr_bseq_state
    import sdr_bseq_pkg::*;
#(
    parameter int COL_W = SDR_COL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             halt,
    input  logic [COL_W-1:0] start,
    input  bmode_t           mode_in,
    input  logic             last_now,
    output logic             active,
    output logic [COL_W-1:0] idx,
    output logic [COL_W-1:0] base,
    output bmode_t           mode
);
    localparam logic [COL_W-1:0] IDX_ONE = COL_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            base   <= '0;
            mode   <= '0;
        end else if (go) begin
            base   <= start;
            mode   <= mode_in;
            idx    <= IDX_ONE;
            active <= ~last_now;
        end else if (halt) begin
            active <= 1'b0;
        end else if (active) begin
            if (last_now)
                active <= 1'b0;
            idx <= idx + IDX_ONE;
        end
    end

    // R2: a running beat that is not final advances the beat index by one
    a_r2_index_step: assert property (@(posedge clk) disable iff (rst)
        (active && !go && !halt && !last_now) |=> (idx == $past(idx) + IDX_ONE));

    // R7: a stop without a new command ends the burst
    a_r7_halt_ends: assert property (@(posedge clk) disable iff (rst)
        (halt && !go) |=> !active);

    // R9: captured settings hold while no command arrives
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
        (!go && !$past(go)) |-> $stable(mode));

    // R8: a command captures its starting column
    a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        go |=> (base == $past(start)));
endmodule

// File: rtl/sdr_burst_colseq.sv
module sdr_burst_colseq
    import sdr_bseq_pkg::*;
#(
    parameter int COL_W = SDR_COL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             col_go,
    input  logic [COL_W-1:0] col_start,
    input  logic [2:0]       len_code,
    input  logic             order_ilv,
    input  logic             burst_halt,
    output logic             beat_valid,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_last
);
    bmode_t           mode_in;
    bmode_t           mode_q;
    bmode_t           mode_sel;
    logic             active_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] base_sel;
    logic [COL_W-1:0] idx_sel;
    logic             gen_last;

    // A new command bypasses the stored burst so beat 0 leaves in its own cycle.
    always_comb begin
        mode_in  = decode_mode(len_code, order_ilv);
        mode_sel = col_go ? mode_in   : mode_q;
        base_sel = col_go ? col_start : base_q;
        idx_sel  = col_go ? '0        : idx_q;
    end

    sdr_bseq_state #(.COL_W(COL_W)) u_state (
        .clk      (clk),
        .rst      (rst),
        .go       (col_go),
        .halt     (burst_halt),
        .start    (col_start),
        .mode_in  (mode_in),
        .last_now (gen_last),
        .active   (active_q),
        .idx      (idx_q),
        .base     (base_q),
        .mode     (mode_q)
    );

    sdr_bseq_addr #(.COL_W(COL_W)) u_addr (
        .base (base_sel),
        .idx  (idx_sel),
        .mode (mode_sel),
        .col  (beat_col),
        .last (gen_last)
    );

    assign beat_valid = col_go | active_q;
    assign beat_last  = beat_valid & gen_last;

    // R1: command cycle presents the starting column
    a_r1_first_beat: assert property (@(posedge clk) disable iff (rst)
        col_go |-> (beat_valid && beat_col == col_start));

    // R3: columns stay inside the aligned block of the captured burst
    a_r3_block_fixed: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !col_go) |-> (((beat_col ^ base_q) & ~span_mask(mode_q)) == '0));

    // R5: a full-page burst never ends by itself
    a_r5_page_runs: assert property (@(posedge clk) disable iff (rst)
        (active_q && mode_q.page && !col_go && !burst_halt) |=> beat_valid);

    // R6: after the final beat nothing follows except a new command
    a_r6_last_closes: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_last) |=> (!beat_valid || col_go));

    // R6: no final-beat flag during a full-page burst
    a_r6_page_no_last: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !col_go && mode_q.page) |-> !beat_last);

    // R10: reset leaves no burst running
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> !active_q);
endmodule

// File: tb/sdr_burst_colseq_bench.sv
module sdr_burst_colseq_bench;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       col_go = 1'b0;
    logic [7:0] col_start = '0;
    logic [2:0] len_code = '0;
    logic       order_ilv = 1'b0;
    logic       burst_halt = 1'b0;
    logic       beat_valid;
    logic [7:0] beat_col;
    logic       beat_last;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    sdr_burst_colseq u_sdr_burst_colseq (
        .clk        (clk),
        .rst        (rst),
        .col_go     (col_go),
        .col_start  (col_start),
        .len_code   (len_code),
        .order_ilv  (order_ilv),
        .burst_halt (burst_halt),
        .beat_valid (beat_valid),
        .beat_col   (beat_col),
        .beat_last  (beat_last)
    );

    function automatic int blen(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 256;
            default: return 1;
        endcase
    endfunction

    function automatic int ecol(input int start, input int code, input bit ilv, input int i);
        int len = blen(code);
        int off = start % len;
        int blk = start - off;
        if (len == 256) return (start + i) % 256;
        if (ilv) return blk + (off ^ i);
        return blk + ((off + i) % len);
    endfunction

    function automatic bit elast(input int code, input int i);
        return (blen(code) != 256) && (i == blen(code) - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, then compare outputs before the next rise.
    task automatic beat(input bit go, input int start, input int code, input bit ilv,
                        input bit halt, input bit ev, input int ec, input bit el,
                        input string req);
        @(negedge clk);
        col_go = go; col_start = 8'(start); len_code = 3'(code);
        order_ilv = ilv; burst_halt = halt;
        #1;
        chk(beat_valid == ev, {req, " valid"}, beat_valid, ev);
        if (ev) begin
            chk(beat_col == 8'(ec), {req, " col"}, beat_col, ec);
            chk(beat_last == el, {req, " last"}, beat_last, el);
        end
    endtask

    task automatic run_burst(input int start, input int code, input bit ilv, input string req);
        int n = blen(code);
        for (int i = 0; i < n; i++)
            beat(i == 0, start, code, ilv, 0, 1, ecol(start, code, ilv, i), elast(code, i), req);
        beat(0, 0, 0, 0, 0, 0, 0, 0, {req, " end"});
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk(beat_valid == 0, "R10 during reset", beat_valid, 0);
        @(negedge clk); rst = 1'b0;
        beat(0, 0, 0, 0, 0, 0, 0, 0, "R10 after reset");
    endtask

    task automatic t_lengths;
        run_burst(8'h35, 2, 0, "R3 seq len4");
        run_burst(8'h1D, 3, 0, "R3 seq len8");
        run_burst(8'h1D, 3, 1, "R4 ilv len8");
        run_burst(8'h36, 2, 1, "R4 ilv len4");
        run_burst(8'h81, 1, 0, "R2 seq len2");
        run_burst(8'h81, 1, 1, "R2 ilv len2");
        run_burst(8'hC7, 0, 1, "R2 len1");
    endtask

    task automatic t_reserved;
        run_burst(8'h4B, 4, 0, "R11 code4");
        run_burst(8'h4B, 5, 1, "R11 code5");
        run_burst(8'h4B, 6, 0, "R11 code6");
    endtask

    task automatic t_full_page;
        for (int i = 0; i < 260; i++)
            beat(i == 0, 8'hFE, 7, 1, 0, 1, ecol(8'hFE, 7, 0, i), 0, "R5 page");
        beat(0, 0, 7, 0, 1, 1, ecol(8'hFE, 7, 0, 260), 0, "R7 page halt cycle");
        beat(0, 0, 7, 0, 0, 0, 0, 0, "R7 page after halt");
    endtask

    task automatic t_halt_mid;
        for (int i = 0; i < 3; i++)
            beat(i == 0, 8'h62, 3, 0, 0, 1, ecol(8'h62, 3, 0, i), 0, "R7 pre");
        beat(0, 0, 3, 0, 1, 1, ecol(8'h62, 3, 0, 3), 0, "R7 halt cycle");
        beat(0, 0, 3, 0, 0, 0, 0, 0, "R7 stopped");
        beat(0, 0, 3, 0, 0, 0, 0, 0, "R7 still stopped");
    endtask

    task automatic t_restart;
        for (int i = 0; i < 3; i++)
            beat(i == 0, 8'h10, 3, 0, 0, 1, ecol(8'h10, 3, 0, i), 0, "R8 old");
        run_burst(8'h42, 2, 1, "R8 restart");
        beat(1, 8'hA5, 1, 0, 0, 1, 8'hA5, 0, "R8 first");
        beat(1, 8'h77, 2, 0, 1, 1, 8'h77, 0, "R8 go beats halt");
        for (int i = 1; i < 4; i++)
            beat(0, 0, 2, 0, 0, 1, ecol(8'h77, 2, 0, i), elast(2, i), "R8 after collision");
        beat(0, 0, 0, 0, 0, 0, 0, 0, "R8 end");
    endtask

    task automatic t_cfg_ignored;
        beat(1, 8'h2B, 3, 1, 0, 1, ecol(8'h2B, 3, 1, 0), 0, "R9 start");
        for (int i = 1; i < 8; i++)
            beat(0, 8'h00, (i % 2) ? 7 : 1, i[0], 0, 1, ecol(8'h2B, 3, 1, i), elast(3, i), "R9 noisy");
        beat(0, 0, 7, 0, 0, 0, 0, 0, "R9 end");
    endtask

    initial begin
        t_reset();
        t_lengths();
        t_reserved();
        t_full_page();
        t_halt_mid();
        t_restart();
        t_cfg_ignored();
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired got=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule